// File: doc/BRIEF.md
# Single-Step Non-Restoring Division Unit

This block keeps the three flags of a bit-serial division protocol: a quotient-sign flag Q, a divisor-sign flag M and a carry-style flag T. It also holds the datapath for one division step. Software divides by issuing one initialise command and then a step command once per quotient bit. It passes the current partial remainder and the divisor on each step, writes the returned remainder back, and collects quotient bits from T.

There are two initialise commands. The unsigned one clears all three flags. The signed one loads Q and M from the sign bits of the remainder and the divisor. Each step does three things. It shifts the current T into the bottom of the remainder. It then adds the divisor to the shifted value or subtracts it, depending on whether Q and M differ. Finally it recomputes Q and T from the carry or borrow.

Software moves the dividend bits into T between steps, so the block also accepts a direct write of T. Iteration control, the rotate of the quotient register and instruction decode stay outside the block.

Top module: `divstep_unit`

## Requirements
- R1: While reset is asserted, and directly after it, the Q, M and T flags are all 0.
- R2: An unsigned-initialise command clears Q, M and T at the next clock edge.
- R3: A signed-initialise command sets Q to the top bit of `rn_in`, M to the top bit of `rm_in`, and T to Q XOR M at the next clock edge.
- R4: `rn_out` is combinational from the inputs and the flags held before the edge. It is S − `rm_in` when Q equals M, and S + `rm_in` when they differ. Here S is `rn_in` shifted left by one with T in bit 0.
- R5: A step loads Q with (top bit of `rn_in`) XOR M XOR c. Here c is the carry out of the add, or the borrow of the subtract, both taken at the full width.
- R6: After a step, T is 1 exactly when the new Q equals M. A step leaves M unchanged.
- R7: A T-write command loads `t_in` into T and leaves Q and M unchanged.
- R8: With no command strobe high, all three flags hold their values, whatever the data inputs do.
- R9: When several strobes are high together, only the highest-priority command acts. The order from highest is unsigned-initialise, signed-initialise, step, then T-write.
- R10: For a divisor that is not zero, the following sequence yields the unsigned quotient. Clear the flags. Then, 32 times: rotate the dividend left through T, then step. Finish with one more rotate.
- R11: The signed sequence yields the quotient truncated toward zero. It sign-extends the remainder, subtracts 1 from a negative dividend, uses signed-initialise, runs the same 32 rotate/step pairs and a final rotate, and adds the last rotated-out bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_unsigned | input | 1 | Unsigned-initialise strobe |
| init_signed | input | 1 | Signed-initialise strobe |
| step | input | 1 | Division-step strobe |
| load_t | input | 1 | T-write strobe |
| t_in | input | 1 | Value written to T by the T-write command |
| rn_in | input | WIDTH | Partial remainder (or dividend high word for signed-initialise) |
| rm_in | input | WIDTH | Divisor |
| rn_out | output | WIDTH | Updated partial remainder of a step |
| q_flag | output | 1 | Q flag |
| m_flag | output | 1 | M flag |
| t_flag | output | 1 | T flag |

## Verification
A wrong Q or M flips the add/subtract choice, so `rn_out` shows it in the same cycle as the next step. A wrong T corrupts bit 0 of `rn_out` at once and the quotient bit one edge later. The bench models the flags behaviourally and compares both the flags and `rn_out` at every clock, so any divergence shows within one cycle of its cause. Complete signed and unsigned divisions then confirm that 32 chained steps stay coherent over long carry and borrow runs.

// File: rtl/divstep_pkg.sv
package divstep_pkg;

   typedef struct packed {
      logic q;
      logic m;
      logic t;
   } divflags_t;

   typedef enum logic [2:0] {
      CMD_IDLE  = 3'd0,
      CMD_UINIT = 3'd1,
      CMD_SINIT = 3'd2,
      CMD_STEP  = 3'd3,
      CMD_TLOAD = 3'd4
   } divcmd_e;

endpackage

// File: rtl/divstep_cmd_sel.sv
module divstep_cmd_sel
   import divstep_pkg::*;
(
   input  logic    init_unsigned,
   input  logic    init_signed,
   input  logic    step,
   input  logic    load_t,
   output divcmd_e cmd
);

   // Fixed priority: unsigned init, signed init, step, T write (R9)
   always_comb begin
      if (init_unsigned)    cmd = CMD_UINIT;
      else if (init_signed) cmd = CMD_SINIT;
      else if (step)        cmd = CMD_STEP;
      else if (load_t)      cmd = CMD_TLOAD;
      else                  cmd = CMD_IDLE;
   end

endmodule

// File: rtl/divstep_alu.sv
module divstep_alu
   import divstep_pkg::*;
#(
   parameter int WIDTH            = 32,
   parameter bit CARRY_BY_COMPARE = 1'b0
) (
   input  logic [WIDTH-1:0] rn,
   input  logic [WIDTH-1:0] rm,
   input  divflags_t        flags,
   output logic [WIDTH-1:0] rn_next,
   output logic             q_next,
   output logic             t_next
);

   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] shifted;
   logic             add_mode;
   logic [WIDTH-1:0] result;
   logic             cout;

   assign shifted  = {rn[MSB-1:0], flags.t};
   assign add_mode = flags.q ^ flags.m;

   generate
      if (CARRY_BY_COMPARE) begin : g_cmp
         // carry/borrow recovered by magnitude compare of result and operand
         always_comb begin
            if (add_mode) begin
               result = shifted + rm;
               cout   = (result < shifted);
            end else begin
               result = shifted - rm;
               cout   = (result > shifted);
            end
         end
      end else begin : g_ext
         // carry/borrow taken from one extra adder bit
         logic [WIDTH:0] ext;
         always_comb begin
            if (add_mode) ext = {1'b0, shifted} + {1'b0, rm};
            else          ext = {1'b0, shifted} - {1'b0, rm};
         end
         assign result = ext[MSB:0];
         assign cout   = ext[WIDTH];
      end
   endgenerate

   assign rn_next = result;
   assign q_next  = rn[MSB] ^ flags.m ^ cout;
   assign t_next  = (q_next == flags.m);

endmodule

// File: rtl/divstep_flag_reg.sv
module divstep_flag_reg
   import divstep_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  divcmd_e   cmd,
   input  logic      sign_rn,
   input  logic      sign_rm,
   input  logic      step_q,
   input  logic      step_t,
   input  logic      t_in,
   output divflags_t flags
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
      end else begin
         unique case (cmd)
            CMD_UINIT: flags <= '0;
            CMD_SINIT: begin
               flags.q <= sign_rn;
               flags.m <= sign_rm;
               flags.t <= sign_rn ^ sign_rm;
            end
            CMD_STEP: begin
               flags.q <= step_q;
               flags.t <= step_t;
            end
            CMD_TLOAD: flags.t <= t_in;
            default: flags <= flags;
         endcase
      end
   end

   AST_UINIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_UINIT) |=> (flags == '0)); // R2

   AST_SINIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_SINIT) |=> (flags.q == $past(sign_rn) && flags.m == $past(sign_rm)
                              && flags.t == (flags.q ^ flags.m))); // R3

   AST_STEP_T_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_STEP) |=> (flags.t == (flags.q == flags.m))); // R6

   AST_STEP_M_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_STEP) |=> $stable(flags.m)); // R6

   AST_TLOAD_ONLY_T: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_TLOAD) |=> (flags.t == $past(t_in) && $stable(flags.q) && $stable(flags.m))); // R7

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_IDLE) |=> $stable(flags)); // R8

endmodule

// File: rtl/divstep_unit.sv
module divstep_unit
   import divstep_pkg::*;
#(
   parameter int WIDTH            = 32,
   parameter bit CARRY_BY_COMPARE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_unsigned,
   input  logic             init_signed,
   input  logic             step,
   input  logic             load_t,
   input  logic             t_in,
   input  logic [WIDTH-1:0] rn_in,
   input  logic [WIDTH-1:0] rm_in,
   output logic [WIDTH-1:0] rn_out,
   output logic             q_flag,
   output logic             m_flag,
   output logic             t_flag
);

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("divstep_unit: WIDTH must be at least 2");
      end
   endgenerate

   divcmd_e   cmd;
   divflags_t flags;
   logic      step_q;
   logic      step_t;

   divstep_cmd_sel i_cmd_sel (
      .init_unsigned (init_unsigned),
      .init_signed   (init_signed),
      .step          (step),
      .load_t        (load_t),
      .cmd           (cmd)
   );

   divstep_alu #(
      .WIDTH            (WIDTH),
      .CARRY_BY_COMPARE (CARRY_BY_COMPARE)
   ) i_alu (
      .rn      (rn_in),
      .rm      (rm_in),
      .flags   (flags),
      .rn_next (rn_out),
      .q_next  (step_q),
      .t_next  (step_t)
   );

   divstep_flag_reg i_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd     (cmd),
      .sign_rn (rn_in[MSB]),
      .sign_rm (rm_in[MSB]),
      .step_q  (step_q),
      .step_t  (step_t),
      .t_in    (t_in),
      .flags   (flags)
   );

   assign q_flag = flags.q;
   assign m_flag = flags.m;
   assign t_flag = flags.t;

   AST_SUB_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
      (q_flag == m_flag) |-> (rn_out + rm_in == {rn_in[MSB-1:0], t_flag})); // R4

   AST_ADD_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
      (q_flag != m_flag) |-> (rn_out - rm_in == {rn_in[MSB-1:0], t_flag})); // R4

endmodule

// File: tb/test_divstep_unit.sv
module test_divstep_unit;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         init_unsigned = 1'b0;
   logic         init_signed = 1'b0;
   logic         step = 1'b0;
   logic         load_t = 1'b0;
   logic         t_in = 1'b0;
   logic [W-1:0] rn_in = '0;
   logic [W-1:0] rm_in = '0;
   logic [W-1:0] rn_out;
   logic         q_flag, m_flag, t_flag;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   bit mq = 1'b0, mm = 1'b0, mt = 1'b0;

   always #4 clk = ~clk;

   divstep_unit i_divstep_unit (
      .clk (clk), .rst_n (rst_n),
      .init_unsigned (init_unsigned), .init_signed (init_signed),
      .step (step), .load_t (load_t), .t_in (t_in),
      .rn_in (rn_in), .rm_in (rm_in), .rn_out (rn_out),
      .q_flag (q_flag), .m_flag (m_flag), .t_flag (t_flag)
   );

   // Behavioural step: arithmetic in 64-bit integers
   function automatic void ref_step(input logic [31:0] rn, input logic [31:0] rm,
                                    input bit q, input bit m, input bit t,
                                    output logic [31:0] r, output bit qn, output bit tn);
      longint unsigned sh, s;
      bit cb;
      sh = ((longint'(rn) * 2) + t) % 64'h1_0000_0000;
      if (q == m) begin
         cb = (longint'(rm) > sh);
         s  = (sh + 64'h1_0000_0000 - rm) % 64'h1_0000_0000;
      end else begin
         s  = sh + rm;
         cb = (s >= 64'h1_0000_0000);
         s  = s % 64'h1_0000_0000;
      end
      r  = s[31:0];
      qn = rn[31] ^ m ^ cb;
      tn = (qn == m);
   endfunction

   // Reference flag model, updated on every rising edge
   always @(posedge clk or negedge rst_n) begin
      logic [31:0] r;
      bit qn, tn;
      if (!rst_n) begin
         mq = 0; mm = 0; mt = 0;
      end else if (init_unsigned) begin
         mq = 0; mm = 0; mt = 0;
      end else if (init_signed) begin
         mq = rn_in[31]; mm = rm_in[31]; mt = rn_in[31] ^ rm_in[31];
      end else if (step) begin
         ref_step(rn_in, rm_in, mq, mm, mt, r, qn, tn);
         mq = qn; mt = tn;
      end else if (load_t) begin
         mt = t_in;
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Per-clock comparison against the model
   always @(negedge clk) begin
      logic [31:0] r;
      bit qn, tn;
      if (rst_n && !done) begin
         chk("R8 flags vs model", {61'd0, q_flag, m_flag, t_flag}, {61'd0, mq, mm, mt});
         ref_step(rn_in, rm_in, mq, mm, mt, r, qn, tn);
         chk("R4 rn_out vs model", {32'd0, rn_out}, {32'd0, r});
      end
   end

   task automatic apply(input bit u, input bit s, input bit st, input bit lt, input bit tv,
                        input logic [31:0] rn, input logic [31:0] rm,
                        output logic [31:0] seen);
      @(negedge clk);
      #2;
      init_unsigned = u; init_signed = s; step = st; load_t = lt; t_in = tv;
      rn_in = rn; rm_in = rm;
      #1 seen = rn_out;
      @(posedge clk);
      #1;
      init_unsigned = 0; init_signed = 0; step = 0; load_t = 0; t_in = 0;
   endtask

   task automatic flags_chk(input string req, input bit q, input bit m, input bit t);
      chk(req, {61'd0, q_flag, m_flag, t_flag}, {61'd0, q, m, t});
   endtask

   task automatic run_div(input bit sgn, input logic [31:0] x, input logic [31:0] d,
                          output logic [31:0] quo);
      logic [31:0] hi, lo, seen;
      bit nt;
      if (sgn) begin
         hi = x[31] ? 32'hFFFF_FFFF : 32'h0;
         lo = x - {31'd0, x[31]};
         apply(0, 1, 0, 0, 0, hi, d, seen);
      end else begin
         hi = 0;
         lo = x;
         apply(1, 0, 0, 0, 0, 0, d, seen);
      end
      for (int i = 0; i < 32; i++) begin
         nt = lo[31];
         lo = {lo[30:0], t_flag};
         apply(0, 0, 0, 1, nt, hi, d, seen);
         apply(0, 0, 1, 0, 0, hi, d, seen);
         hi = seen;
      end
      nt = lo[31];
      lo = {lo[30:0], t_flag};
      quo = sgn ? lo + {31'd0, nt} : lo;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] seen, quo;
      int unsigned lcg;
      int sx, sd;
      repeat (3) @(posedge clk);
      #1 flags_chk("R1 reset", 0, 0, 0);
      @(negedge clk);
      rst_n = 1;
      #1 flags_chk("R1 after reset", 0, 0, 0);

      // R3 signed initialise, several sign mixes
      apply(0, 1, 0, 0, 0, 32'h8000_0000, 32'h0000_0001, seen);
      flags_chk("R3 neg/pos", 1, 0, 1);
      apply(1, 0, 0, 0, 0, 32'h1234_5678, 32'hFFFF_0000, seen);
      flags_chk("R2 clear", 0, 0, 0);
      apply(0, 1, 0, 0, 0, 32'h0, 32'hFFFF_FFFF, seen);
      flags_chk("R3 pos/neg", 0, 1, 1);
      apply(0, 1, 0, 0, 0, 32'hFFFF_FFFF, 32'h8000_0000, seen);
      flags_chk("R3 neg/neg", 1, 1, 0);

      // R4 R5 R6 subtract without borrow
      apply(1, 0, 0, 0, 0, 0, 0, seen);
      apply(0, 0, 1, 0, 0, 32'd5, 32'd3, seen);
      chk("R4 subtract", {32'd0, seen}, 64'd7);
      flags_chk("R5 R6 no borrow", 0, 0, 1);
      // subtract with borrow
      apply(1, 0, 0, 0, 0, 0, 0, seen);
      apply(0, 0, 1, 0, 0, 32'd1, 32'd5, seen);
      chk("R4 subtract wrap", {32'd0, seen}, {32'd0, 32'hFFFF_FFFD});
      flags_chk("R5 R6 borrow", 1, 0, 0);
      // add with carry, T=1 shifted in
      apply(0, 1, 0, 0, 0, 32'h8000_0000, 32'h0, seen);
      apply(0, 0, 1, 0, 0, 32'h7FFF_FFFF, 32'd1, seen);
      chk("R4 add carry", {32'd0, seen}, 64'd0);
      flags_chk("R5 R6 carry, M kept", 1, 0, 0);

      // R7 T write
      apply(0, 1, 0, 0, 0, 32'h8000_0000, 32'h8000_0000, seen);
      apply(0, 0, 0, 1, 1, 32'h0, 32'h0, seen);
      flags_chk("R7 T set", 1, 1, 1);
      apply(0, 0, 0, 1, 0, 32'hFFFF_FFFF, 32'h0, seen);
      flags_chk("R7 T clear", 1, 1, 0);

      // R8 idle hold while data toggles
      for (int i = 0; i < 4; i++) begin
         apply(0, 0, 0, 0, 1, 32'hFFFF_FFFF ^ i, 32'h8000_0000 + i, seen);
         flags_chk("R8 hold", 1, 1, 0);
      end

      // R9 priority
      apply(1, 1, 1, 1, 1, 32'h8000_0000, 32'h8000_0000, seen);
      flags_chk("R9 unsigned init wins", 0, 0, 0);
      apply(0, 1, 1, 1, 1, 32'h0, 32'h8000_0000, seen);
      flags_chk("R9 signed init beats step", 0, 1, 1);
      apply(1, 0, 0, 0, 0, 0, 0, seen);
      apply(0, 0, 1, 1, 1, 32'h0, 32'h8000_0000, seen);
      flags_chk("R9 step beats T write", 1, 0, 0);

      // R10 unsigned divisions
      run_div(0, 32'd100, 32'd7, quo);          chk("R10 100/7", {32'd0, quo}, 64'd14);
      run_div(0, 32'hFFFF_FFFF, 32'd1, quo);    chk("R10 max/1", {32'd0, quo}, {32'd0, 32'hFFFF_FFFF});
      run_div(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, quo); chk("R10 max/max", {32'd0, quo}, 64'd1);
      run_div(0, 32'd7, 32'd9, quo);            chk("R10 7/9", {32'd0, quo}, 64'd0);
      run_div(0, 32'h8000_0000, 32'd3, quo);    chk("R10 2^31/3", {32'd0, quo}, {32'd0, 32'h8000_0000 / 3});
      lcg = 32'h1357_9BDF;
      for (int i = 0; i < 6; i++) begin
         logic [31:0] a, b;
         lcg = lcg * 1664525 + 1013904223; a = lcg;
         lcg = lcg * 1664525 + 1013904223; b = lcg >> (lcg % 29);
         if (b == 0) b = 1;
         run_div(0, a, b, quo);
         chk("R10 random", {32'd0, quo}, {32'd0, a / b});
      end

      // R11 signed divisions
      run_div(1, -32'sd100, 32'sd7, quo);  chk("R11 -100/7", {32'd0, quo}, {32'd0, -32'sd14});
      run_div(1, 32'sd100, -32'sd7, quo);  chk("R11 100/-7", {32'd0, quo}, {32'd0, -32'sd14});
      run_div(1, -32'sd100, -32'sd7, quo); chk("R11 -100/-7", {32'd0, quo}, 64'd14);
      run_div(1, 32'sd7, -32'sd9, quo);    chk("R11 7/-9", {32'd0, quo}, 64'd0);
      run_div(1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, quo);
      chk("R11 max/-1", {32'd0, quo}, {32'd0, 32'h8000_0001});
      for (int i = 0; i < 6; i++) begin
         lcg = lcg * 1664525 + 1013904223; sx = int'(lcg);
         lcg = lcg * 1664525 + 1013904223; sd = int'(lcg) >>> (lcg % 29);
         if (sd == 0) sd = 3;
         if (sx == int'(32'h8000_0000)) sx = sx + 1;
         run_div(1, sx, sd, quo);
         chk("R11 random", {32'd0, quo}, {32'd0, sx / sd});
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule